// File: doc/BRIEF.md
# Two-Digit Rate-Selectable Decimal Counter

This block counts from 00 to 99 and back, one step per tick, and shows each decimal digit on its own common-anode seven-segment display. The tick comes from a divider that runs on the fast system clock (50 MHz by default). A 2-bit select input picks one of four step rates: 0.5, 1, 2 or 4 steps per second. The divider does not make a second clock. It makes a one-cycle enable pulse, so every register in the block stays on the system clock.

An up/down input sets the direction. The ones digit carries into the tens digit going up and borrows from it going down. The count wraps at both ends. An active-low clear acts at once, without waiting for a clock edge, and sets both digits to zero. Each digit's BCD value is also brought out so the count can be watched directly.

Top module: `dual_bcd_rate_counter`

## Requirements
- R1: While `clr_n` is low, both digits read 0 and both segment buses show the zero pattern 0000001. This takes effect at once, with no clock edge needed.
- R2: While `rate_sel` is held, the count moves exactly once every L system-clock cycles. L is `P_LIM_HALF` for select 0, `P_LIM_ONE` for 1, `P_LIM_TWO` for 2 and `P_LIM_FOUR` for 3 (defaults 100,000,000 / 50,000,000 / 25,000,000 / 12,500,000).
- R3: A change of `rate_sel` restarts the divider. The clock edge that first samples the new select produces no step. The first step then lands L(new)+1 edges later, and later steps come every L(new) edges.
- R4: Counting up (`up_dn` = 1), a ones digit below 9 increments. A ones digit of 9 goes to 0 and the tens digit increments.
- R5: Counting up from 99 gives 00.
- R6: Counting down (`up_dn` = 0), a ones digit of 0 goes to 9 and the tens digit decrements. A nonzero ones digit decrements alone.
- R7: Counting down from 00 gives 99.
- R8: The direction is sampled on the clock edge that applies a step. Changes between steps only decide the next step.
- R9: Each segment bus is active-low, with segment a in bit 6 down to segment g in bit 0. The digits 0 to 9 show as 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 1100000, 0001111, 0000000 and 0001100.
- R10: Neither BCD digit output ever exceeds 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| rate_sel | input | 2 | Step-rate select (0: slowest … 3: fastest) |
| up_dn | input | 1 | 1 counts up, 0 counts down |
| seg_tens | output | 7 | Active-low segments of the tens digit, a in bit 6 |
| seg_ones | output | 7 | Active-low segments of the ones digit, a in bit 6 |
| bcd_tens | output | 4 | Tens digit value |
| bcd_ones | output | 4 | Ones digit value |

## Verification
The hardest case to reach from the ports is a rate change in the middle of an interval. There the restart has to be told apart from a divider that simply keeps its old count. The stimulus waits a few cycles after a step and only then switches the select. It then measures the exact number of cycles to the next visible step and compares it with L(new)+2 sampling points. Both wrap boundaries in both directions come from running the fastest rate, with shortened reload parameters, through a full hundred-step sweep and back down past zero. A direction flip placed between two steps shows that only the level at the step edge counts.

// File: rtl/rate_cnt_pkg.sv
package rate_cnt_pkg;

    typedef logic [3:0] bcd_t;
    typedef logic [6:0] seg_t;

    typedef enum logic [1:0] {
        RATE_HALF = 2'd0,
        RATE_ONE  = 2'd1,
        RATE_TWO  = 2'd2,
        RATE_FOUR = 2'd3
    } rate_e;

    typedef struct packed {
        logic en;
        logic up;
    } step_t;

    localparam bcd_t DIGIT_MAX = 4'd9;
    localparam seg_t SEG_DARK  = 7'b1111111;

    // Active-low pattern, bit 6 = segment a, bit 0 = segment g.
    function automatic seg_t bcd_to_seg(input bcd_t v);
        seg_t s;
        case (v)
            4'd0:    s = 7'b0000001;
            4'd1:    s = 7'b1001111;
            4'd2:    s = 7'b0010010;
            4'd3:    s = 7'b0000110;
            4'd4:    s = 7'b1001100;
            4'd5:    s = 7'b0100100;
            4'd6:    s = 7'b1100000;
            4'd7:    s = 7'b0001111;
            4'd8:    s = 7'b0000000;
            4'd9:    s = 7'b0001100;
            default: s = SEG_DARK;
        endcase
        return s;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
    import rate_cnt_pkg::*;
#(
    parameter int unsigned P_LIM_HALF = 100_000_000,
    parameter int unsigned P_LIM_ONE  = 50_000_000,
    parameter int unsigned P_LIM_TWO  = 25_000_000,
    parameter int unsigned P_LIM_FOUR = 12_500_000
) (
    input  logic  clk,
    input  logic  clr_n,
    input  rate_e sel_i,
    output logic  tick_o
);
    localparam int unsigned LIM_MAX = max4(P_LIM_HALF, P_LIM_ONE, P_LIM_TWO, P_LIM_FOUR);
    localparam int CW = (LIM_MAX > 1) ? $clog2(LIM_MAX) : 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_c;
    rate_e         sel_q;
    logic          sel_chg;
    logic          at_end;

    always_comb begin
        case (sel_i)
            RATE_HALF: last_c = CW'(P_LIM_HALF - 1);
            RATE_ONE:  last_c = CW'(P_LIM_ONE - 1);
            RATE_TWO:  last_c = CW'(P_LIM_TWO - 1);
            default:   last_c = CW'(P_LIM_FOUR - 1);
        endcase
    end

    assign sel_chg = (sel_i != sel_q);
    assign at_end  = (cnt_q == last_c);

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            cnt_q  <= '0;
            sel_q  <= RATE_HALF;
            tick_o <= 1'b0;
        end else begin
            sel_q  <= sel_i;
            tick_o <= at_end && !sel_chg;
            if (sel_chg || at_end) cnt_q <= '0;
            else                   cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bcd_digit.sv
module bcd_digit
    import rate_cnt_pkg::*;
(
    input  logic  clk,
    input  logic  clr_n,
    input  step_t step_i,
    output bcd_t  val_o,
    output logic  carry_o
);
    bcd_t nxt;

    always_comb begin
        if (step_i.up) nxt = (val_o >= DIGIT_MAX) ? 4'd0 : val_o + 4'd1;
        else           nxt = (val_o == 4'd0 || val_o > DIGIT_MAX) ? DIGIT_MAX : val_o - 4'd1;
    end

    assign carry_o = step_i.en && (step_i.up ? (val_o == DIGIT_MAX) : (val_o == 4'd0));

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)          val_o <= 4'd0;
        else if (step_i.en)  val_o <= nxt;
    end
endmodule

// File: rtl/bcd_seg_enc.sv
module bcd_seg_enc
    import rate_cnt_pkg::*;
(
    input  bcd_t digit_i,
    output seg_t seg_o
);
    assign seg_o = bcd_to_seg(digit_i);
endmodule

// File: rtl/dual_bcd_rate_counter.sv
module dual_bcd_rate_counter
    import rate_cnt_pkg::*;
#(
    parameter int unsigned P_LIM_HALF = 100_000_000,
    parameter int unsigned P_LIM_ONE  = 50_000_000,
    parameter int unsigned P_LIM_TWO  = 25_000_000,
    parameter int unsigned P_LIM_FOUR = 12_500_000
) (
    input  logic       clk,
    input  logic       clr_n,
    input  logic [1:0] rate_sel,
    input  logic       up_dn,
    output logic [6:0] seg_tens,
    output logic [6:0] seg_ones,
    output logic [3:0] bcd_tens,
    output logic [3:0] bcd_ones
);
    localparam int NDIG = 2;

    logic  tick_w;
    step_t step_w  [NDIG];
    bcd_t  val_w   [NDIG];
    seg_t  seg_w   [NDIG];
    logic  carry_w [NDIG];

    rate_tick_gen #(
        .P_LIM_HALF(P_LIM_HALF),
        .P_LIM_ONE (P_LIM_ONE),
        .P_LIM_TWO (P_LIM_TWO),
        .P_LIM_FOUR(P_LIM_FOUR)
    ) u_tick (
        .clk   (clk),
        .clr_n (clr_n),
        .sel_i (rate_e'(rate_sel)),
        .tick_o(tick_w)
    );

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        if (i == 0) begin : g_first
            assign step_w[i] = '{en: tick_w, up: up_dn};
        end else begin : g_next
            assign step_w[i] = '{en: carry_w[i-1], up: up_dn};
        end

        bcd_digit u_digit (
            .clk    (clk),
            .clr_n  (clr_n),
            .step_i (step_w[i]),
            .val_o  (val_w[i]),
            .carry_o(carry_w[i])
        );

        bcd_seg_enc u_enc (
            .digit_i(val_w[i]),
            .seg_o  (seg_w[i])
        );
    end

    assign bcd_ones = val_w[0];
    assign bcd_tens = val_w[1];
    assign seg_ones = seg_w[0];
    assign seg_tens = seg_w[1];
endmodule

// File: rtl/dual_bcd_rate_counter_chk.sv
module dual_bcd_rate_counter_chk
    import rate_cnt_pkg::*;
(
    input logic       clk,
    input logic       clr_n,
    input logic [1:0] rate_sel,
    input logic       up_dn,
    input logic       tick,
    input bcd_t       ones,
    input bcd_t       tens,
    input seg_t       seg_ones
);
    // R1: clear holds both digits at zero
    always @(negedge clk) begin
        if (clr_n == 1'b0) begin
            p_clear_zero_r1: assert (ones == 4'd0 && tens == 4'd0);
        end
    end

    p_step_needs_tick_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !$past(tick) |-> ($stable(ones) && $stable(tens)));

    p_sel_restart_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (rate_sel != $past(rate_sel)) |=> !tick);

    p_up_ones_r4: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(tick) && $past(up_dn) && $past(ones) != 4'd9)
        |-> (ones == $past(ones) + 4'd1 && tens == $past(tens)));

    p_up_wrap_r5: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(tick) && $past(up_dn) && $past(ones) == 4'd9 && $past(tens) == 4'd9)
        |-> (ones == 4'd0 && tens == 4'd0));

    p_down_borrow_r6: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(tick) && !$past(up_dn) && $past(ones) == 4'd0 && $past(tens) != 4'd0)
        |-> (ones == 4'd9 && tens == $past(tens) - 4'd1));

    p_down_wrap_r7: assert property (@(posedge clk) disable iff (!clr_n)
        ($past(tick) && !$past(up_dn) && $past(ones) == 4'd0 && $past(tens) == 4'd0)
        |-> (ones == 4'd9 && tens == 4'd9));

    p_zero_seg_r9: assert property (@(posedge clk) disable iff (!clr_n)
        (ones == 4'd0) |-> (seg_ones == 7'b0000001));

    p_bcd_range_r10: assert property (@(posedge clk) disable iff (!clr_n)
        (ones <= 4'd9 && tens <= 4'd9));
endmodule

bind dual_bcd_rate_counter dual_bcd_rate_counter_chk u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .rate_sel(rate_sel),
    .up_dn   (up_dn),
    .tick    (tick_w),
    .ones    (bcd_ones),
    .tens    (bcd_tens),
    .seg_ones(seg_ones)
);

// File: tb/test_dual_bcd_rate_counter.sv
module test_dual_bcd_rate_counter;
    localparam int CLK_PERIOD = 10;
    localparam int L0 = 40;
    localparam int L1 = 20;
    localparam int L2 = 10;
    localparam int L3 = 5;

    logic       clk = 1'b0;
    logic       clr_n;
    logic [1:0] rate_sel = 2'd0;
    logic       up_dn = 1'b1;
    logic [6:0] seg_tens, seg_ones;
    logic [3:0] bcd_tens, bcd_ones;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit cmp_on = 0;
    string cur_req = "R2";

    logic [6:0] seg_tab [10];

    // behavioural reference
    int m_val = 0;
    int m_cnt = 0;
    int m_lim;
    logic [1:0] m_selq = 2'd0;
    bit m_tick = 0;
    bit m_chg;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bcd_rate_counter #(
        .P_LIM_HALF(L0), .P_LIM_ONE(L1), .P_LIM_TWO(L2), .P_LIM_FOUR(L3)
    ) i_dual_bcd_rate_counter (
        .clk(clk), .clr_n(clr_n), .rate_sel(rate_sel), .up_dn(up_dn),
        .seg_tens(seg_tens), .seg_ones(seg_ones),
        .bcd_tens(bcd_tens), .bcd_ones(bcd_ones)
    );

    function automatic int lim_of(input logic [1:0] s);
        case (s)
            2'd0: return L0;
            2'd1: return L1;
            2'd2: return L2;
            default: return L3;
        endcase
    endfunction

    always @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            m_val = 0; m_cnt = 0; m_selq = 2'd0; m_tick = 0;
        end else begin
            m_lim = lim_of(rate_sel);
            m_chg = (rate_sel != m_selq);
            m_selq = rate_sel;
            if (m_tick) m_val = up_dn ? (m_val + 1) % 100 : (m_val + 99) % 100;
            m_tick = !m_chg && (m_cnt == m_lim - 1);
            if (m_chg || m_cnt == m_lim - 1) m_cnt = 0;
            else m_cnt = m_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison with the reference
    always @(negedge clk) begin
        cycles++;
        if (cmp_on) begin
            chk(bcd_ones == 4'(m_val % 10) && bcd_tens == 4'(m_val / 10),
                cur_req, int'(bcd_tens) * 10 + int'(bcd_ones), m_val);
            chk(seg_ones == seg_tab[m_val % 10] && seg_tens == seg_tab[m_val / 10],
                "R9", int'({seg_tens, seg_ones}),
                int'({seg_tab[m_val / 10], seg_tab[m_val % 10]}));
        end
        if (cycles > 60000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 60000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int cur_val();
        return int'(bcd_tens) * 10 + int'(bcd_ones);
    endfunction

    task automatic wait_change(output int n);
        int prev;
        prev = cur_val();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (cur_val() == prev && n < 500);
    endtask

    initial begin
        int n;
        int v;
        seg_tab[0] = 7'b0000001; seg_tab[1] = 7'b1001111; seg_tab[2] = 7'b0010010;
        seg_tab[3] = 7'b0000110; seg_tab[4] = 7'b1001100; seg_tab[5] = 7'b0100100;
        seg_tab[6] = 7'b1100000; seg_tab[7] = 7'b0001111; seg_tab[8] = 7'b0000000;
        seg_tab[9] = 7'b0001100;

        clr_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bcd_ones == 0 && bcd_tens == 0, "R1", cur_val(), 0);
        chk(seg_ones == 7'b0000001 && seg_tens == 7'b0000001, "R1",
            int'({seg_tens, seg_ones}), int'({7'b0000001, 7'b0000001}));
        cmp_on = 1;
        clr_n = 1'b1;

        // R2: steady spacing at select 0
        cur_req = "R2";
        wait_change(n);
        wait_change(n);
        chk(n == L0, "R2", n, L0);
        wait_change(n);
        chk(n == L0, "R2", n, L0);

        // R3: select change mid-interval restarts the divider
        cur_req = "R3";
        repeat (7) @(negedge clk);
        rate_sel = 2'd1;
        wait_change(n);
        chk(n == L1 + 2 - 7 + 7, "R3", n, L1 + 2);
        wait_change(n);
        chk(n == L1, "R3", n, L1);

        // fastest rate, up sweep: R4, R5, R9, R10
        rate_sel = 2'd3;
        up_dn = 1'b1;
        cur_req = "R4";
        wait_change(n);
        for (int k = 0; k < 120; k++) begin
            v = cur_val();
            wait_change(n);
            chk(bcd_ones <= 9 && bcd_tens <= 9, "R10", cur_val(), 0);
            if (v == 99)
                chk(cur_val() == 0, "R5", cur_val(), 0);
            else if (v % 10 == 9)
                chk(cur_val() == v + 1 && bcd_ones == 0, "R4", cur_val(), v + 1);
            else
                chk(cur_val() == v + 1, "R4", cur_val(), v + 1);
            chk(seg_ones == seg_tab[bcd_ones % 10], "R9", int'(seg_ones),
                int'(seg_tab[bcd_ones % 10]));
        end

        // down sweep: R6, R7
        cur_req = "R6";
        up_dn = 1'b0;
        wait_change(n);
        for (int k = 0; k < 120; k++) begin
            v = cur_val();
            wait_change(n);
            if (v == 0)
                chk(cur_val() == 99, "R7", cur_val(), 99);
            else
                chk(cur_val() == v - 1, "R6", cur_val(), v - 1);
        end

        // R8: direction flipped between steps; only the step-edge level counts
        cur_req = "R8";
        wait_change(n);
        v = cur_val();
        up_dn = 1'b1;
        @(negedge clk);
        up_dn = 1'b0;
        wait_change(n);
        chk(cur_val() == (v + 99) % 100, "R8", cur_val(), (v + 99) % 100);
        v = cur_val();
        up_dn = 1'b1;
        wait_change(n);
        chk(cur_val() == (v + 1) % 100, "R8", cur_val(), (v + 1) % 100);

        // R1: asynchronous clear between edges
        @(negedge clk);
        #(CLK_PERIOD/5);
        clr_n = 1'b0;
        #1;
        chk(bcd_ones == 0 && bcd_tens == 0, "R1", cur_val(), 0);
        chk(seg_ones == 7'b0000001 && seg_tens == 7'b0000001, "R1",
            int'({seg_tens, seg_ones}), int'({7'b0000001, 7'b0000001}));
        @(negedge clk);
        clr_n = 1'b1;
        repeat (30) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule